// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block sits next to a memory and keeps, for every memory block, one presence bit per processor and a single dirty bit. Processors send it read and write requests that name the requester, the operation and the block index. The controller looks up the entry for that block and decides what coherence work is needed. A clean read is answered straight from memory. A block held dirty by another processor is first recalled from that owner. A write to a shared block first invalidates every other sharer. The requester then gets a reply that carries the block data. Invalidations and recalls go only to the processors whose presence bits are set. Nothing is ever broadcast.

The controller serves one transaction at a time and accepts a new request only when it is idle. Recall and invalidate commands leave on a single message port, one command per cycle. Recalled data comes back on a return port. It is written into memory before the reply is sent. The memory is a plain register model whose reset contents are computed from the block index.

Top module: `pbdir_ctrl`

## Requirements
- R1: After reset every entry has no sharers and a clear dirty bit, `req_ready` is high, no message or reply is valid, and block b holds the word SEED + b (default SEED = 0xD1C00000).
- R2: A read of a clean block by processor i produces a single reply to i carrying the memory word and no message. Afterwards i is a sharer.
- R3: A read by i of a block that another processor o holds dirty sends one recall-to-shared command (message kind 1) to o. The controller then waits for `rcl_valid`, stores `rcl_data` in memory and replies to i with that data. The dirty bit is then clear, and both o and i are sharers.
- R4: A write by i to a clean block sends an invalidate command (message kind 3) to each other sharer, one per cycle in ascending processor id, and then replies to i with the memory word. Afterwards i is the only sharer and the block is dirty.
- R5: A write by i to a block that another processor o holds dirty sends one recall-and-invalidate command (message kind 2) to o. It stores the returned data in memory and replies to i with it. Afterwards i alone holds the block dirty.
- R6: A read or write by the processor that already holds the block dirty gets a reply with the memory word, no message is sent, and the entry is left unchanged.
- R7: Every message goes to a processor whose presence bit is set in the entry, and an invalidate never goes to the requester.
- R8: `req_ready` goes low in the cycle after a request is accepted, stays low for as long as recall data is awaited, and returns high in the cycle after the reply.
- R9: A dirty entry always has exactly one presence bit set, and that bit names the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_pid | input | log2(NPROC) | Requesting processor id |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_blk | input | log2(NBLK) | Block index |
| msg_valid | output | 1 | Coherence command valid this cycle |
| msg_kind | output | 2 | 1 recall-to-shared, 2 recall-and-invalidate, 3 invalidate |
| msg_dest | output | log2(NPROC) | Target processor of the command |
| msg_blk | output | log2(NBLK) | Block the command refers to |
| rcl_valid | input | 1 | Recalled data present |
| rcl_data | input | DW | Recalled block data |
| rsp_valid | output | 1 | Reply valid (one cycle) |
| rsp_dest | output | log2(NPROC) | Processor receiving the reply |
| rsp_blk | output | log2(NBLK) | Block of the reply |
| rsp_data | output | DW | Block data supplied to the requester |

## Verification
A stale or corrupted presence vector shows up at the message port on the next write to that block. That write either sends an invalidate to a processor that never read the block or misses one that did, within a few cycles of acceptance. A dirty bit that is wrong changes the next request's path: a recall appears where a direct reply was due, or the reply carries old memory data in place of the recalled word. A memory update that is lost only shows up on a later clean read of the same block. For that reason the bench rereads blocks after every recall.

// File: rtl/pbdir_pkg.sv
package pbdir_pkg;

    typedef enum logic [1:0] {
        MK_NONE    = 2'd0,
        MK_RCL_SHR = 2'd1,
        MK_RCL_INV = 2'd2,
        MK_INV     = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECALL,
        ST_WAIT,
        ST_INV,
        ST_REPLY
    } seq_st_e;

    function automatic msg_kind_e recall_kind(input logic is_write);
        return is_write ? MK_RCL_INV : MK_RCL_SHR;
    endfunction

endpackage

// File: rtl/pbdir_pick.sv
module pbdir_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0]                     vec,
    output logic [((W > 1) ? $clog2(W) : 1)-1:0] idx,
    output logic                             any
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pbdir_store.sv
module pbdir_store #(
    parameter int          NPROC = 4,
    parameter int          NBLK  = 16,
    parameter int          DW    = 32,
    parameter logic [DW-1:0] SEED = 32'hD1C0_0000,
    localparam int         BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BW-1:0]    lk_blk,
    output logic [NPROC-1:0] lk_pres,
    output logic             lk_dirty,
    input  logic [BW-1:0]    rd_blk,
    output logic [DW-1:0]    rd_data,
    input  logic             dir_we,
    input  logic [BW-1:0]    dir_blk,
    input  logic [NPROC-1:0] dir_pres,
    input  logic             dir_dirty,
    input  logic             mem_we,
    input  logic [BW-1:0]    mem_blk,
    input  logic [DW-1:0]    mem_data
);
    logic [NPROC-1:0] pres_q [NBLK];
    logic [NBLK-1:0]  dirty_q;
    logic [DW-1:0]    mem_q  [NBLK];

    for (genvar b = 0; b < NBLK; b++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                pres_q[b]  <= '0;
                dirty_q[b] <= 1'b0;
            end else if (dir_we && dir_blk == BW'(b)) begin
                pres_q[b]  <= dir_pres;
                dirty_q[b] <= dir_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[b] <= SEED + DW'(b);
            end else if (mem_we && mem_blk == BW'(b)) begin
                mem_q[b] <= mem_data;
            end
        end

        AST_DIRTY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            dirty_q[b] |-> ($countones(pres_q[b]) == 1)) else $error("dirty entry without single owner"); // R9
    end

    assign lk_pres  = pres_q[lk_blk];
    assign lk_dirty = dirty_q[lk_blk];
    assign rd_data  = mem_q[rd_blk];

    AST_DIRTY_WRITE_OWNER: assert property (@(posedge clk) disable iff (rst)
        (dir_we && dir_dirty) |-> ($countones(dir_pres) == 1)) else $error("dirty write with bad presence"); // R9
endmodule

// File: rtl/pbdir_seq.sv
module pbdir_seq
    import pbdir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 16,
    parameter int DW    = 32,
    localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int BW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PW-1:0]    req_pid,
    input  logic             req_write,
    input  logic [BW-1:0]    req_blk,
    input  logic [NPROC-1:0] lk_pres,
    input  logic             lk_dirty,
    input  logic [PW-1:0]    own_idx,
    output logic [NPROC-1:0] pend,
    input  logic [PW-1:0]    inv_idx,
    output logic             msg_valid,
    output msg_kind_e        msg_kind,
    output logic [PW-1:0]    msg_dest,
    output logic [BW-1:0]    msg_blk,
    input  logic             rcl_valid,
    input  logic [DW-1:0]    rcl_data,
    output logic             mem_we,
    output logic [BW-1:0]    mem_blk,
    output logic [DW-1:0]    mem_data,
    output logic [BW-1:0]    rd_blk,
    output logic             dir_we,
    output logic [BW-1:0]    dir_blk,
    output logic [NPROC-1:0] dir_pres,
    output logic             dir_dirty,
    output logic             rsp_valid,
    output logic [PW-1:0]    rsp_dest,
    output logic [BW-1:0]    rsp_blk
);
    seq_st_e          st_q, st_n;
    logic [PW-1:0]    pid_q;
    logic             wr_q;
    logic [BW-1:0]    blk_q;
    logic [PW-1:0]    own_q;
    logic [NPROC-1:0] ent_pres_q;
    logic             ent_dirty_q;
    logic [NPROC-1:0] pend_q, pend_n;

    logic [NPROC-1:0] req_bit, pid_bit, others;
    logic             self_own;

    assign req_bit  = NPROC'(1) << req_pid;
    assign pid_bit  = NPROC'(1) << pid_q;
    assign others   = lk_pres & ~req_bit;
    assign self_own = ent_dirty_q && (own_q == pid_q);
    assign pend     = pend_q;

    always_comb begin
        st_n   = st_q;
        pend_n = pend_q;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (lk_dirty && own_idx != req_pid) begin
                        st_n = ST_RECALL;
                    end else if (req_write && !lk_dirty && |others) begin
                        st_n   = ST_INV;
                        pend_n = others;
                    end else begin
                        st_n = ST_REPLY;
                    end
                end
            end
            ST_RECALL: st_n = ST_WAIT;
            ST_WAIT:   if (rcl_valid) st_n = ST_REPLY;
            ST_INV: begin
                pend_n = pend_q & ~(NPROC'(1) << inv_idx);
                if (pend_n == '0) st_n = ST_REPLY;
            end
            ST_REPLY:  st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            pid_q       <= '0;
            wr_q        <= 1'b0;
            blk_q       <= '0;
            own_q       <= '0;
            ent_pres_q  <= '0;
            ent_dirty_q <= 1'b0;
            pend_q      <= '0;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
            if (st_q == ST_IDLE && req_valid) begin
                pid_q       <= req_pid;
                wr_q        <= req_write;
                blk_q       <= req_blk;
                own_q       <= own_idx;
                ent_pres_q  <= lk_pres;
                ent_dirty_q <= lk_dirty;
            end
        end
    end

    assign req_ready = (st_q == ST_IDLE);

    always_comb begin
        msg_valid = 1'b0;
        msg_kind  = MK_NONE;
        msg_dest  = '0;
        if (st_q == ST_RECALL) begin
            msg_valid = 1'b1;
            msg_kind  = recall_kind(wr_q);
            msg_dest  = own_q;
        end else if (st_q == ST_INV) begin
            msg_valid = 1'b1;
            msg_kind  = MK_INV;
            msg_dest  = inv_idx;
        end
    end
    assign msg_blk = blk_q;

    assign mem_we   = (st_q == ST_WAIT) && rcl_valid;
    assign mem_blk  = blk_q;
    assign mem_data = rcl_data;
    assign rd_blk   = blk_q;

    assign rsp_valid = (st_q == ST_REPLY);
    assign rsp_dest  = pid_q;
    assign rsp_blk   = blk_q;

    assign dir_we    = (st_q == ST_REPLY) && !self_own;
    assign dir_blk   = blk_q;
    assign dir_pres  = wr_q ? pid_bit : (ent_pres_q | pid_bit);
    assign dir_dirty = wr_q;

    AST_MSG_TO_SHARER: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> ent_pres_q[msg_dest]) else $error("message to non-sharer"); // R7
    AST_INV_NOT_SELF: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MK_INV) |-> (msg_dest != pid_q)) else $error("invalidate to requester"); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready) else $error("ready after accept"); // R8
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && !rcl_valid) |=> (st_q == ST_WAIT && !req_ready)) else $error("left wait early"); // R8
    AST_READY_AFTER_REPLY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready) else $error("not ready after reply"); // R8
endmodule

// File: rtl/pbdir_ctrl.sv
module pbdir_ctrl
    import pbdir_pkg::*;
#(
    parameter int            NPROC = 4,
    parameter int            NBLK  = 16,
    parameter int            DW    = 32,
    parameter logic [DW-1:0] SEED  = 32'hD1C0_0000,
    localparam int           PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int           BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [PW-1:0] req_pid,
    input  logic          req_write,
    input  logic [BW-1:0] req_blk,
    output logic          msg_valid,
    output logic [1:0]    msg_kind,
    output logic [PW-1:0] msg_dest,
    output logic [BW-1:0] msg_blk,
    input  logic          rcl_valid,
    input  logic [DW-1:0] rcl_data,
    output logic          rsp_valid,
    output logic [PW-1:0] rsp_dest,
    output logic [BW-1:0] rsp_blk,
    output logic [DW-1:0] rsp_data
);
    logic [NPROC-1:0] lk_pres, pend, dir_pres;
    logic             lk_dirty, own_any, inv_any, dir_we, dir_dirty, mem_we;
    logic [PW-1:0]    own_idx, inv_idx;
    logic [BW-1:0]    rd_blk, dir_blk, mem_blk;
    logic [DW-1:0]    mem_data;
    msg_kind_e        kind;

    pbdir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .SEED(SEED)) u_store (
        .clk(clk), .rst(rst),
        .lk_blk(req_blk), .lk_pres(lk_pres), .lk_dirty(lk_dirty),
        .rd_blk(rd_blk), .rd_data(rsp_data),
        .dir_we(dir_we), .dir_blk(dir_blk), .dir_pres(dir_pres), .dir_dirty(dir_dirty),
        .mem_we(mem_we), .mem_blk(mem_blk), .mem_data(mem_data)
    );

    pbdir_pick #(.W(NPROC)) u_own (.vec(lk_pres), .idx(own_idx), .any(own_any));
    pbdir_pick #(.W(NPROC)) u_inv (.vec(pend),    .idx(inv_idx), .any(inv_any));

    pbdir_seq #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_pid(req_pid),
        .req_write(req_write), .req_blk(req_blk),
        .lk_pres(lk_pres), .lk_dirty(lk_dirty), .own_idx(own_idx),
        .pend(pend), .inv_idx(inv_idx),
        .msg_valid(msg_valid), .msg_kind(kind), .msg_dest(msg_dest), .msg_blk(msg_blk),
        .rcl_valid(rcl_valid), .rcl_data(rcl_data),
        .mem_we(mem_we), .mem_blk(mem_blk), .mem_data(mem_data),
        .rd_blk(rd_blk),
        .dir_we(dir_we), .dir_blk(dir_blk), .dir_pres(dir_pres), .dir_dirty(dir_dirty),
        .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_blk(rsp_blk)
    );

    assign msg_kind = kind;

    AST_DIRTY_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lk_dirty) |-> own_any) else $error("dirty block without owner"); // R9
    AST_INV_HAS_TARGET: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && kind == MK_INV) |-> inv_any) else $error("invalidate with empty pending set"); // R4
endmodule

// File: tb/sim_pbdir_ctrl.sv
`timescale 1ns/1ps
module sim_pbdir_ctrl;
    localparam int NP = 4;
    localparam int NB = 16;
    localparam logic [31:0] SEED = 32'hD1C0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_pid = '0;
    logic        req_write = 1'b0;
    logic [3:0]  req_blk = '0;
    logic        msg_valid;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_dest;
    logic [3:0]  msg_blk;
    logic        rcl_valid = 1'b0;
    logic [31:0] rcl_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_dest;
    logic [3:0]  rsp_blk;
    logic [31:0] rsp_data;

    always #2.5 clk = ~clk;

    pbdir_ctrl u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_pid(req_pid),
        .req_write(req_write), .req_blk(req_blk),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest), .msg_blk(msg_blk),
        .rcl_valid(rcl_valid), .rcl_data(rcl_data),
        .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_blk(rsp_blk), .rsp_data(rsp_data)
    );

    typedef struct {
        bit          is_rsp;
        int          kind;
        int          dest;
        int          blk;
        logic [31:0] data;
        string       tag;
    } ev_t;

    ev_t         sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [3:0]  m_pres [NB];
    bit          m_dirty[NB];
    logic [31:0] m_mem  [NB];
    bit          m_used [NB];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pack_ev(input bit r, input int k, input int d, input int b, input logic [31:0] x);
        return {7'd0, r, 4'(k), 4'(d), 8'(b), 8'd0, x};
    endfunction

    // monitor: pops expected items and compares with what the ports show
    always @(negedge clk) begin
        if (!rst && !done && (msg_valid || rsp_valid)) begin
            logic [63:0] act;
            act = msg_valid ? pack_ev(1'b0, int'(msg_kind), int'(msg_dest), int'(msg_blk), 32'd0)
                            : pack_ev(1'b1, 0, int'(rsp_dest), int'(rsp_blk), rsp_data);
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected output", act, 64'd0);
            end else begin
                ev_t e;
                logic [63:0] exp;
                e = sb.pop_front();
                exp = pack_ev(e.is_rsp, e.kind, e.dest, e.blk, e.data);
                chk(act == exp, e.tag, act, exp);
            end
        end
    end

    task automatic push(input bit r, input int k, input int d, input int b, input logic [31:0] x, input string t);
        ev_t e;
        e.is_rsp = r; e.kind = k; e.dest = d; e.blk = b; e.data = x; e.tag = t;
        sb.push_back(e);
    endtask

    task automatic do_req(input int pid, input bit wr, input int blk, input logic [31:0] rdata);
        int    owner;
        bit    recall;
        string t;
        owner = 0;
        for (int j = NP - 1; j >= 0; j--) if (m_pres[blk][j]) owner = j;
        recall = m_dirty[blk] && owner != pid;
        if (recall) begin
            t = wr ? "R5 R9 recall-inv" : "R3 R9 recall-share";
            push(1'b0, wr ? 2 : 1, owner, blk, 32'd0, t);
            m_mem[blk] = rdata;
            push(1'b1, 0, pid, blk, rdata, t);
        end else if (m_dirty[blk]) begin
            push(1'b1, 0, pid, blk, m_mem[blk], "R6 owner access");
        end else if (wr) begin
            for (int j = 0; j < NP; j++)
                if (m_pres[blk][j] && j != pid) push(1'b0, 3, j, blk, 32'd0, "R4 R7 invalidate");
            push(1'b1, 0, pid, blk, m_mem[blk], m_used[blk] ? "R4 write reply" : "R1 R4 init data");
        end else begin
            push(1'b1, 0, pid, blk, m_mem[blk], m_used[blk] ? "R2 clean read" : "R1 R2 init data");
        end
        if (!(m_dirty[blk] && owner == pid)) begin
            if (wr) begin
                m_pres[blk]  = 4'(1 << pid);
                m_dirty[blk] = 1'b1;
            end else begin
                m_pres[blk]  = m_pres[blk] | 4'(1 << pid);
                m_dirty[blk] = 1'b0;
            end
        end
        m_used[blk] = 1'b1;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_pid = 2'(pid); req_write = wr; req_blk = 4'(blk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 busy after accept", {63'd0, req_ready}, 64'd0);
        if (recall) begin
            repeat (3) @(negedge clk);
            chk(!req_ready, "R8 held while waiting recall", {63'd0, req_ready}, 64'd0);
            rcl_valid = 1'b1; rcl_data = rdata;
            @(negedge clk);
            rcl_valid = 1'b0;
        end
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int b = 0; b < NB; b++) begin
            m_pres[b] = '0; m_dirty[b] = 1'b0; m_mem[b] = SEED + 32'(b); m_used[b] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {63'd0, req_ready}, 64'd1);
        chk(!msg_valid && !rsp_valid, "R1 quiet after reset", {62'd0, msg_valid, rsp_valid}, 64'd0);

        do_req(0, 0, 3, 0);
        do_req(1, 0, 3, 0);
        do_req(2, 0, 3, 0);
        do_req(3, 1, 3, 0);            // invalidates 0,1,2
        do_req(1, 0, 3, 32'hCAFE_0001); // recall-share from 3
        do_req(2, 0, 3, 0);
        do_req(2, 1, 3, 0);            // invalidates 1,3
        do_req(0, 1, 3, 32'hBEEF_0002); // recall-inv from 2
        do_req(0, 1, 3, 0);            // owner write
        do_req(0, 0, 3, 0);            // owner read
        do_req(1, 1, 15, 0);           // write, no sharers
        do_req(3, 0, 15, 32'h1234_5678);
        do_req(2, 0, 15, 0);           // reread after recall
        do_req(0, 0, 0, 0);

        lf = 16'hACE1;
        for (int n = 0; n < 80; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_req(int'(lf[1:0]), lf[2], int'(lf[4:3]), {lf, ~lf});
        end

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R7 all expected outputs seen", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule